// File: doc/BRIEF.md
# Single-Subarray Line Controller for One Memory Channel

This block runs one memory channel built so that every 64-byte cache line sits whole inside one subarray of one DRAM chip. The channel has eight chips, and each chip has a private 8-bit data lane. A line request carries a line address and a tag. The low address bits pick the chip. The request waits in that chip's own queue, so a busy chip never holds up work bound for another chip.

For each access, a chip's sequencer sends one posted command that carries the row and the column together. It then collects the line one byte per beat over 64 beats and closes the row with a precharge. The page is never left open. A chip with nothing to do powers down after a fixed number of idle cycles. It pays a fixed wake-up delay before its next command.

The assembled line is returned with the request's tag and the chip number. Lines from different chips can therefore finish in any order relative to one another.

Top module: `ssa_channel_ctrl`

## Requirements
- R1: After reset, every chip's power-down output is 1, no command or precharge pulse is driven, `resp_valid` is 0 and `req_ready` is 1.
- R2: The target chip is `req_addr[2:0]`. The command for that chip carries `req_addr[23:3]` on its 21-bit slice of `chip_cmd_addr` (bits `c*21 +: 21`). No other chip receives a command for that request.
- R3: Each access produces exactly one single-cycle posted command pulse on its chip, carrying row and column together. The first data beat is sampled 4 cycles after the cycle of that pulse.
- R4: The line is gathered over 64 consecutive beats from the chip's 8-bit lane `chip_dq[c*8 +: 8]`. Beat k fills bits `8k+7:8k` of `resp_data`.
- R5: Close-page policy: exactly one precharge pulse is issued per access, in the cycle right after the last beat. That is the cycle in which the response is first offered.
- R6: A request to a powered-down chip drops that chip's power-down output for exactly 3 cycles before its command pulse. A request to a chip that is awake and idle issues its command on the second cycle after acceptance, with no power-down in between.
- R7: A chip with an empty queue asserts power-down after its precharge cycles plus 8 idle cycles. Counted from the first response cycle, this is the 10th cycle later, and power-down is still 0 on the 9th.
- R8: Each chip queues up to 4 requests. `req_ready` is 0 while the addressed chip's queue is full, and a request offered then is not taken. Requests addressed to other chips stay ready.
- R9: Chips work in parallel. Five requests to five different powered-down chips, offered back to back, all complete within 90 cycles of the first acceptance.
- R10: Each response carries the tag and the chip index. Responses from one chip come back in acceptance order. A chip that finishes earlier answers first, even if its request was accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Line request offered |
| req_ready | output | 1 | Addressed chip's queue has room |
| req_addr | input | 24 | Line address; bits 2:0 select the chip |
| req_tag | input | 4 | Requester's tag, returned with the line |
| chip_cmd_valid | output | 8 | Per-chip posted row+column command pulse |
| chip_cmd_addr | output | 168 | Per-chip 21-bit bank/subarray/row/column locator |
| chip_pre | output | 8 | Per-chip precharge pulse |
| chip_pd | output | 8 | Per-chip power-down request |
| chip_dq | input | 64 | Per-chip 8-bit read data lanes |
| resp_valid | output | 1 | A finished line is offered this cycle |
| resp_tag | output | 4 | Tag of the offered line |
| resp_chip | output | 3 | Chip the line came from |
| resp_data | output | 512 | Assembled 64-byte line |

## Verification
The bench drives the main read path with five kinds of request pattern:
- A lone request to a sleeping chip, which isolates the wake delay and the exact beat alignment.
- A follow-up to the same chip while it is still idle, which separates the awake path from the wake path.
- A burst of four requests to one chip, which fills its queue. It shows that a full queue stalls only that chip's traffic and that one chip answers in order.
- Back-to-back requests spread over five chips, whose completion time tells overlapped service apart from serial service.
- A mixed pattern in which a later request to a free chip overtakes queued work on another chip, which proves that tags rather than order identify responses.

A chip model answers each command with a byte pattern derived from the locator. A wrong locator, a shifted beat or a swapped byte therefore shows up as a data mismatch.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef enum logic [2:0] {
    CS_PDN  = 3'd0,
    CS_WAKE = 3'd1,
    CS_ACT  = 3'd2,
    CS_XFER = 3'd3,
    CS_PRE  = 3'd4,
    CS_IDLE = 3'd5
  } chip_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ssa_req_fifo.sv
module ssa_req_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) wr_d = bump(wr_q);
    if (pop)  rd_d = bump(rd_q);
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full)
    else $error("queue written while full");

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty)
    else $error("queue read while empty");

endmodule

// File: rtl/ssa_chip_ctrl.sv
module ssa_chip_ctrl
  import ssa_pkg::*;
#(
  parameter int LOC_W    = 21,
  parameter int TAG_W    = 4,
  parameter int DQ_W     = 8,
  parameter int BEATS    = 64,
  parameter int ACT_CYC  = 4,
  parameter int WAKE_CYC = 3,
  parameter int PRE_CYC  = 2,
  parameter int IDLE_LIM = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  q_empty,
  input  logic [LOC_W-1:0]      q_loc,
  input  logic [TAG_W-1:0]      q_tag,
  output logic                  q_pop,
  output logic                  cmd_valid,
  output logic [LOC_W-1:0]      cmd_loc,
  output logic                  pre,
  output logic                  pd,
  input  logic [DQ_W-1:0]       dq,
  input  logic                  rsp_grant,
  output logic                  rsp_pend,
  output logic [TAG_W-1:0]      rsp_tag,
  output logic [BEATS*DQ_W-1:0] rsp_line
);
  localparam int MAXC   = max2(max2(BEATS, ACT_CYC), max2(max2(WAKE_CYC, PRE_CYC), IDLE_LIM));
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] ACT_LAST  = CNT_W'(ACT_CYC - 1);
  localparam logic [CNT_W-1:0] BEAT_LAST = CNT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_LIM - 1);

  chip_st_e              st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  pend_q, pend_d;
  logic                  line_we;
  logic [LOC_W-1:0]      loc_q;
  logic [TAG_W-1:0]      tag_q;
  logic [BEATS*DQ_W-1:0] line_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    q_pop   = 1'b0;
    line_we = 1'b0;
    pend_d  = pend_q && !rsp_grant;
    unique case (st_q)
      CS_PDN: begin
        if (!q_empty) begin
          st_d  = CS_WAKE;
          cnt_d = '0;
        end
      end
      CS_WAKE: begin
        if (cnt_q == WAKE_LAST) begin
          st_d  = CS_ACT;
          cnt_d = '0;
          q_pop = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      CS_IDLE: begin
        if (!q_empty) begin
          st_d  = CS_ACT;
          cnt_d = '0;
          q_pop = 1'b1;
        end else if (cnt_q == IDLE_LAST) begin
          st_d  = CS_PDN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      CS_ACT: begin
        if (cnt_q == ACT_LAST) begin
          st_d  = CS_XFER;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      CS_XFER: begin
        line_we = 1'b1;
        if (cnt_q == BEAT_LAST) begin
          st_d   = CS_PRE;
          cnt_d  = '0;
          pend_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      CS_PRE: begin
        if (cnt_q != PRE_LAST) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else if (!pend_d) begin
          st_d  = CS_IDLE;
          cnt_d = '0;
        end
      end
      default: begin
        st_d  = CS_PDN;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_PDN;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      tag_q <= '0;
    end else if (q_pop) begin
      loc_q <= q_loc;
      tag_q <= q_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (line_we) line_q[cnt_q[BEAT_W-1:0]*DQ_W +: DQ_W] <= dq;
  end

  assign cmd_valid = (st_q == CS_ACT) && (cnt_q == '0);
  assign pre       = (st_q == CS_PRE) && (cnt_q == '0);
  assign pd        = (st_q == CS_PDN);
  assign cmd_loc   = loc_q;
  assign rsp_pend  = pend_q;
  assign rsp_tag   = tag_q;
  assign rsp_line  = line_q;

  // R3: one posted command, never two in a row
  a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid)
    else $error("command pulse longer than one cycle");

  a_r5_pre_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> ($past(st_q) == CS_XFER))
    else $error("precharge not right after the transfer");

  a_r7_pd_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> ($past(st_q) == CS_IDLE) && $past(q_empty))
    else $error("power-down entered with work pending");

  a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rsp_grant) |=> pend_q)
    else $error("finished line dropped without a grant");

endmodule

// File: rtl/ssa_resp_arb.sv
module ssa_resp_arb #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (grant == '0)) grant[i] = 1'b1;
    end
  end

  assign any = |pend;

  a_r10_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant))
    else $error("more than one response granted");

  a_r10_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~pend) == '0) && (any == (grant != '0)))
    else $error("grant does not match pending lines");

endmodule

// File: rtl/ssa_channel_ctrl.sv
module ssa_channel_ctrl #(
  parameter int NUM_CHIPS  = 8,
  parameter int LADDR_W    = 24,
  parameter int TAG_W      = 4,
  parameter int DQ_W       = 8,
  parameter int LINE_BYTES = 64,
  parameter int QDEPTH     = 4,
  parameter int ACT_CYC    = 4,
  parameter int WAKE_CYC   = 3,
  parameter int PRE_CYC    = 2,
  parameter int IDLE_LIM   = 8,
  localparam int CH_W   = $clog2(NUM_CHIPS),
  localparam int LOC_W  = LADDR_W - CH_W,
  localparam int LINE_W = LINE_BYTES * DQ_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [LADDR_W-1:0]        req_addr,
  input  logic [TAG_W-1:0]          req_tag,
  output logic [NUM_CHIPS-1:0]      chip_cmd_valid,
  output logic [NUM_CHIPS*LOC_W-1:0] chip_cmd_addr,
  output logic [NUM_CHIPS-1:0]      chip_pre,
  output logic [NUM_CHIPS-1:0]      chip_pd,
  input  logic [NUM_CHIPS*DQ_W-1:0] chip_dq,
  output logic                      resp_valid,
  output logic [TAG_W-1:0]          resp_tag,
  output logic [CH_W-1:0]           resp_chip,
  output logic [LINE_W-1:0]         resp_data
);
  localparam int ENT_W = LOC_W + TAG_W;

  logic [1:0]           rs_q;
  logic                 rst_n_i;
  logic [CH_W-1:0]      sel;
  logic                 req_fire;
  logic [NUM_CHIPS-1:0] q_full, q_empty, q_pop, q_push, pend, grant;
  logic [ENT_W-1:0]     q_out [NUM_CHIPS];
  logic [TAG_W-1:0]     tag_a [NUM_CHIPS];
  logic [LINE_W-1:0]    line_a [NUM_CHIPS];

  // reset: asserted at once, released two clean edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  assign sel       = req_addr[CH_W-1:0];
  assign req_ready = !q_full[sel];
  assign req_fire  = req_valid && req_ready;

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    assign q_push[c] = req_fire && (sel == CH_W'(c));

    ssa_req_fifo #(
      .W     (ENT_W),
      .DEPTH (QDEPTH)
    ) u_q (
      .clk   (clk),
      .rst_n (rst_n_i),
      .push  (q_push[c]),
      .pop   (q_pop[c]),
      .din   ({req_addr[LADDR_W-1:CH_W], req_tag}),
      .dout  (q_out[c]),
      .full  (q_full[c]),
      .empty (q_empty[c])
    );

    ssa_chip_ctrl #(
      .LOC_W    (LOC_W),
      .TAG_W    (TAG_W),
      .DQ_W     (DQ_W),
      .BEATS    (LINE_BYTES),
      .ACT_CYC  (ACT_CYC),
      .WAKE_CYC (WAKE_CYC),
      .PRE_CYC  (PRE_CYC),
      .IDLE_LIM (IDLE_LIM)
    ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .q_empty   (q_empty[c]),
      .q_loc     (q_out[c][ENT_W-1:TAG_W]),
      .q_tag     (q_out[c][TAG_W-1:0]),
      .q_pop     (q_pop[c]),
      .cmd_valid (chip_cmd_valid[c]),
      .cmd_loc   (chip_cmd_addr[c*LOC_W +: LOC_W]),
      .pre       (chip_pre[c]),
      .pd        (chip_pd[c]),
      .dq        (chip_dq[c*DQ_W +: DQ_W]),
      .rsp_grant (grant[c]),
      .rsp_pend  (pend[c]),
      .rsp_tag   (tag_a[c]),
      .rsp_line  (line_a[c])
    );
  end

  ssa_resp_arb #(
    .N (NUM_CHIPS)
  ) u_arb (
    .clk   (clk),
    .rst_n (rst_n_i),
    .pend  (pend),
    .grant (grant),
    .any   (resp_valid)
  );

  always_comb begin
    resp_tag  = '0;
    resp_chip = '0;
    resp_data = '0;
    for (int c = 0; c < NUM_CHIPS; c++) begin
      if (grant[c]) begin
        resp_tag  = tag_a[c];
        resp_chip = CH_W'(c);
        resp_data = line_a[c];
      end
    end
  end

endmodule

// File: tb/tb_ssa_channel_ctrl.sv
`timescale 1ns/100ps
module tb_ssa_channel_ctrl;
  localparam int NCH  = 8;
  localparam int LOCW = 21;
  localparam int ACT  = 4;
  localparam int IDL  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [23:0]     req_addr;
  logic [3:0]      req_tag;
  logic [NCH-1:0]  chip_cmd_valid, chip_pre, chip_pd;
  logic [NCH*LOCW-1:0] chip_cmd_addr;
  logic [NCH*8-1:0] chip_dq;
  logic            resp_valid;
  logic [3:0]      resp_tag;
  logic [2:0]      resp_chip;
  logic [511:0]    resp_data;

  always #2 clk = ~clk;

  ssa_channel_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tag(req_tag), .chip_cmd_valid(chip_cmd_valid),
    .chip_cmd_addr(chip_cmd_addr), .chip_pre(chip_pre), .chip_pd(chip_pd),
    .chip_dq(chip_dq), .resp_valid(resp_valid), .resp_tag(resp_tag),
    .resp_chip(resp_chip), .resp_data(resp_data)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int cmd_cnt [NCH];
  int pre_cnt [NCH];
  int cmd_cyc [NCH];
  int beat_pos [NCH];
  logic [LOCW-1:0] mloc [NCH];
  logic [7:0] dq_a [NCH];
  logic [23:0] tag_addr [16];
  int rn = 0;
  logic [3:0] r_tag [64];
  int r_chip [64];
  bit r_ok [64];
  bit r_pre [64];
  int r_cyc [64];

  always_comb begin
    for (int c = 0; c < NCH; c++) chip_dq[c*8 +: 8] = dq_a[c];
  end

  function automatic logic [7:0] pat(input logic [LOCW-1:0] loc, input int c, input int k);
    return (loc[7:0] ^ 8'(c * 37)) + 8'(k * 3) + 8'd1;
  endfunction

  function automatic logic [511:0] exp_line(input logic [23:0] a);
    logic [511:0] l;
    for (int k = 0; k < 64; k++) l[k*8 +: 8] = pat(a[23:3], int'(a[2:0]), k);
    return l;
  endfunction

  function automatic logic [23:0] mk(input int loc, input int c);
    return {21'(loc), 3'(c)};
  endfunction

  // chip model and response monitor
  initial begin
    for (int c = 0; c < NCH; c++) begin
      cmd_cnt[c] = 0; pre_cnt[c] = 0; cmd_cyc[c] = 0;
      beat_pos[c] = -1000; mloc[c] = '0; dq_a[c] = 8'h00;
    end
    forever begin
      @(negedge clk);
      cyc++;
      for (int c = 0; c < NCH; c++) begin
        if (chip_cmd_valid[c]) begin
          cmd_cnt[c]++;
          cmd_cyc[c] = cyc;
          mloc[c] = chip_cmd_addr[c*LOCW +: LOCW];
          beat_pos[c] = 0;
        end else if (beat_pos[c] >= 0) begin
          beat_pos[c]++;
        end
        if (chip_pre[c]) pre_cnt[c]++;
        if (beat_pos[c] - ACT >= 0 && beat_pos[c] - ACT < 64)
          dq_a[c] = pat(mloc[c], c, beat_pos[c] - ACT);
        else
          dq_a[c] = 8'h00;
      end
      if (resp_valid && rn < 64) begin
        r_tag[rn]  = resp_tag;
        r_chip[rn] = int'(resp_chip);
        r_ok[rn]   = (resp_data == exp_line(tag_addr[resp_tag]));
        r_pre[rn]  = chip_pre[resp_chip];
        r_cyc[rn]  = cyc;
        rn++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [23:0] a, input logic [3:0] t);
    tag_addr[t] = a;
    req_addr  = a;
    req_tag   = t;
    req_valid = 1'b1;
    #0.5;
    while (!req_ready) step();
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_resp(input int n);
    int t = 0;
    while (rn < n && t < 3000) begin
      step();
      t++;
    end
  endtask

  task automatic t_reset();
    chk(chip_pd == '1, "R1", "pd after reset", chip_pd, 8'hff);
    chk(chip_cmd_valid == '0 && chip_pre == '0, "R1", "cmd/pre after reset",
        {chip_cmd_valid, chip_pre}, 0);
    chk(!resp_valid, "R1", "resp_valid after reset", resp_valid, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
  endtask

  task automatic t_sleep_then_idle();
    int pdlow = 0;
    int base = rn;
    bit seen = 0;
    logic [23:0] a = mk(21'h0ABCD, 5);
    send(a, 4'd1);
    for (int i = 0; i < 20; i++) begin
      step();
      if (chip_cmd_valid[5]) begin seen = 1; break; end
      if (!chip_pd[5]) pdlow++;
    end
    chk(seen && pdlow == 3, "R6", "wake cycles before command", pdlow, 3);
    chk(chip_cmd_addr[5*LOCW +: LOCW] == a[23:3], "R2", "command locator",
        chip_cmd_addr[5*LOCW +: LOCW], a[23:3]);
    chk(cmd_cnt[5] == 1 && cmd_cnt[0] + cmd_cnt[1] + cmd_cnt[2] + cmd_cnt[3]
        + cmd_cnt[4] + cmd_cnt[6] + cmd_cnt[7] == 0, "R2", "commands on chip 5 only",
        cmd_cnt[5], 1);
    wait_resp(base + 1);
    chk(r_tag[base] == 4'd1 && r_chip[base] == 5, "R10", "tag/chip",
        {r_tag[base], 4'(r_chip[base])}, 8'h15);
    chk(r_ok[base], "R4", "line data chip 5", r_ok[base], 1);
    chk(r_cyc[base] - cmd_cyc[5] == ACT + 64, "R3", "command to response distance",
        r_cyc[base] - cmd_cyc[5], ACT + 64);
    chk(r_pre[base] && pre_cnt[5] == 1, "R5", "precharge with response",
        pre_cnt[5], 1);
    chk(cmd_cnt[5] == 1, "R3", "one posted command per access", cmd_cnt[5], 1);
    // second request while idle: no wake penalty
    step(); step();
    a = mk(21'h01234, 5);
    send(a, 4'd2);
    step();
    chk(!chip_cmd_valid[5] && !chip_pd[5], "R6", "idle: first cycle after accept",
        {chip_cmd_valid[5], chip_pd[5]}, 0);
    step();
    chk(chip_cmd_valid[5] && !chip_pd[5], "R6", "idle: command second cycle",
        {chip_cmd_valid[5], chip_pd[5]}, 2);
    wait_resp(base + 2);
    chk(r_tag[base+1] == 4'd2 && r_ok[base+1], "R4", "line data from idle path",
        r_ok[base+1], 1);
    for (int k = 0; k < 9; k++) step();
    chk(!chip_pd[5], "R7", "pd still low 9 cycles after response", chip_pd[5], 0);
    step();
    chk(chip_pd[5], "R7", "pd high 10 cycles after response", chip_pd[5], 1);
    chk(pre_cnt[5] == 2, "R5", "precharge count chip 5", pre_cnt[5], 2);
  endtask

  task automatic t_queue_full();
    int base = rn;
    int extra = 0;
    for (int i = 0; i < 4; i++) send(mk(21'h10000 + i * 77, 3), 4'(4 + i));
    req_addr = mk(21'h1FFFF, 3);
    #0.5;
    chk(!req_ready, "R8", "ready low for full chip 3", req_ready, 0);
    req_addr = mk(21'h1FFFF, 4);
    #0.5;
    chk(req_ready, "R8", "ready high for chip 4", req_ready, 1);
    tag_addr[8] = mk(21'h1FFFF, 3);
    req_addr = mk(21'h1FFFF, 3);
    req_tag = 4'd8;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    wait_resp(base + 4);
    for (int k = 0; k < 200; k++) step();
    for (int i = 0; i < 4; i++) begin
      chk(r_tag[base+i] == 4'(4 + i) && r_chip[base+i] == 3 && r_ok[base+i], "R10",
          "in-order response from chip 3", r_tag[base+i], 4 + i);
    end
    for (int i = base; i < rn; i++) if (r_tag[i] == 4'd8) extra++;
    chk(extra == 0 && cmd_cnt[3] == 4, "R8", "request offered while full not taken",
        cmd_cnt[3], 4);
    chk(pre_cnt[3] == 4, "R5", "one precharge per access", pre_cnt[3], 4);
  endtask

  task automatic t_parallel();
    int base = rn;
    int start;
    int chips [5] = '{0, 1, 2, 6, 7};
    bit ok = 1;
    start = cyc;
    for (int i = 0; i < 5; i++) send(mk(21'h02000 + i * 311, chips[i]), 4'(9 + i));
    wait_resp(base + 5);
    for (int i = 0; i < 5; i++) if (!r_ok[base+i]) ok = 0;
    chk(ok && rn == base + 5, "R9", "all parallel lines correct", rn - base, 5);
    chk(r_cyc[base+4] - start <= 90, "R9", "parallel completion time",
        r_cyc[base+4] - start, 90);
  endtask

  task automatic t_out_of_order();
    int base = rn;
    send(mk(21'h03000, 4), 4'd14);
    send(mk(21'h03100, 4), 4'd15);
    send(mk(21'h03200, 6), 4'd0);
    wait_resp(base + 3);
    chk(r_tag[base] == 4'd14 && r_tag[base+1] == 4'd0 && r_tag[base+2] == 4'd15,
        "R10", "completion order 14,0,15",
        {r_tag[base], r_tag[base+1], r_tag[base+2]}, 12'hE0F);
    chk(r_ok[base] && r_ok[base+1] && r_ok[base+2] && r_chip[base+1] == 6,
        "R4", "line data out of order", r_chip[base+1], 6);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_tag = '0;
    for (int i = 0; i < 16; i++) tag_addr[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_sleep_then_idle();
    repeat (12) step();
    t_queue_full();
    repeat (12) step();
    t_parallel();
    repeat (12) step();
    t_out_of_order();
    repeat (5) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule